// File: doc/BRIEF.md
# Cache Tag Store with Comparator

This block is a tag memory for a secondary cache. Each entry holds a tag and three status bits. An index input selects one entry. The stored tag is compared with the tag presented on the input in the same cycle, and the result appears on a hit flag with no clock delay. Reads are also combinational. Writes to the tag field and to the status field each have their own enable and take effect at the rising clock edge.

A single synchronous invalidate input, sampled low at a clock edge, clears the status bits of every entry at once. The tags are not touched. A mode input selects how the status bits behave:

- **Dedicated mode:** the bits mean valid, dirty and write-through, and the valid bit qualifies the hit.
- **Generic mode:** the bits are plain user storage and take no part in qualification.

A burst-ready output, active low, is formed inside the block from the hit, the status bits, the processor write/read direction, a force-inactive input and an external ready input. This lets a cache controller skip a level of decision logic. The default index width is 8 bits; set it to 14 for the full 16K-entry organisation.

Top module: `tagstore_cmp`

## Requirements
- R1: With both chip selects active and the matching output enable set, `tag_out` shows the stored tag and `stat_out` shows the stored status of the entry at `addr`. Both follow `addr` combinationally. Status encoding: bit 0 valid, bit 1 dirty, bit 2 write-through.
- R2: `hit` is high when the chip is selected, the stored tag at `addr` equals `tag_in`, and the mode qualification (R6/R7) allows it. Otherwise `hit` is low. It changes combinationally.
- R3: Writes happen only at the rising clock edge. While `tag_wr` is high before the edge, `tag_out` still shows the old tag. After the edge, the entry holds `tag_in`.
- R4: `tag_wr` writes only the tag field, leaving the status field of the entry unchanged. `stat_wr` writes only the status field, leaving the tag unchanged.
- R5: `inval_n` low at a rising edge clears all status bits of every entry. Tags are kept.
- R6: With `generic_mode` = 0, `hit` requires the stored valid bit (bit 0) to be 1.
- R7: With `generic_mode` = 1, the status bits are stored and read back unchanged. `hit` ignores them, and burst-ready ignores the write-through bit.
- R8: The chip is selected only when `sel0_n` = 0 and `sel1` = 1. When it is deselected:
  - no write takes place;
  - `hit` is 0;
  - `tag_out` and `stat_out` are 0.
- R9: `tag_out` is 0 when `tag_oe` = 0, and `stat_out` is 0 when `stat_oe` = 0. Neither enable affects `hit`.
- R10: With `rdy_oe` = 1 and `rdy_force_hi` = 0, `brdy_n` is 0 in any of these cases, and 1 otherwise:
  - a hit with `bus_write` = 0;
  - a hit with `bus_write` = 1 to an entry whose write-through bit is 0 (dedicated mode);
  - `rdy_ext_n` = 0.
- R11: `brdy_n` is 1 whenever `rdy_force_hi` = 1 or `rdy_oe` = 0.
- R12: When `inval_n` is low at an edge that also has `stat_wr` set, the status of the addressed entry ends at 0. A tag write at that same edge still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| inval_n | input | 1 | Synchronous bulk status clear, active low |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| addr | input | ADDR_W | Entry index |
| tag_in | input | TAG_W | Tag to compare and to write |
| stat_in | input | 3 | Status bits to write |
| tag_wr | input | 1 | Tag field write enable |
| stat_wr | input | 1 | Status field write enable |
| tag_oe | input | 1 | Tag read output enable |
| stat_oe | input | 1 | Status read output enable |
| generic_mode | input | 1 | 1: status bits are user bits |
| bus_write | input | 1 | Processor cycle direction, 1 = write |
| rdy_force_hi | input | 1 | Forces burst-ready inactive |
| rdy_ext_n | input | 1 | External ready, active low |
| rdy_oe | input | 1 | Burst-ready output enable |
| tag_out | output | TAG_W | Stored tag read data |
| stat_out | output | 3 | Stored status read data |
| hit | output | 1 | Qualified tag match |
| brdy_n | output | 1 | Burst ready, active low |

## Verification
The assertions run on every cycle and check the following:
- a hit always implies equal tags, and in dedicated mode a set valid bit;
- a deselected chip drives quiet outputs;
- the force and enable inputs hold burst-ready inactive;
- each write enable lands its own field and leaves the other field unchanged;
- an invalidate clears the addressed status.

Only the bench scenarios show the following:
- the clear reaches entries other than the one addressed;
- writes attempted while deselected are dropped;
- the pre-edge read returns old data;
- the burst-ready decision is correct across read, write, write-through and external-ready cases.

// File: rtl/tagstore_pkg.sv
package tagstore_pkg;
    localparam int STAT_W = 3;

    typedef struct packed {
        logic wt;
        logic dty;
        logic vld;
    } stat_t;
endpackage

// File: rtl/tagstore_array.sv
module tagstore_array
    import tagstore_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              inval_n,
    input  logic              wr_tag,
    input  logic              wr_stat,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  tag_wdata,
    input  stat_t             stat_wdata,
    output logic [TAG_W-1:0]  tag_rd,
    output stat_t             stat_rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [TAG_W-1:0] tag_q  [DEPTH];
    logic [TAG_W-1:0] tag_d  [DEPTH];
    stat_t            stat_q [DEPTH];
    stat_t            stat_d [DEPTH];

    always_comb begin
        tag_d  = tag_q;
        stat_d = stat_q;
        if (wr_tag) begin
            tag_d[addr] = tag_wdata;
        end
        if (!inval_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stat_d[i] = '0;
            end
        end else if (wr_stat) begin
            stat_d[addr] = stat_wdata;
        end
    end

    always_ff @(posedge clk) begin
        tag_q  <= tag_d;
        stat_q <= stat_d;
    end

    assign tag_rd  = tag_q[addr];
    assign stat_rd = stat_q[addr];

    // Assertion support: enables checks only after the first edge.
    logic past_ok = 1'b0;
    always_ff @(posedge clk) past_ok <= 1'b1;

    assert_tag_write_lands_R3: assert property (@(posedge clk) disable iff (!past_ok)
        wr_tag |=> tag_q[$past(addr)] == $past(tag_wdata));

    assert_stat_write_keeps_tag_R4: assert property (@(posedge clk) disable iff (!past_ok)
        (wr_stat && !wr_tag) |=> tag_q[$past(addr)] == $past(tag_rd));

    assert_tag_write_keeps_stat_R4: assert property (@(posedge clk) disable iff (!past_ok)
        (wr_tag && !wr_stat && inval_n) |=> stat_q[$past(addr)] == $past(stat_rd));

    assert_inval_clears_R5: assert property (@(posedge clk) disable iff (!past_ok)
        !inval_n |=> stat_q[$past(addr)] == '0);

    assert_inval_beats_write_R12: assert property (@(posedge clk) disable iff (!past_ok)
        (!inval_n && wr_stat) |=> stat_q[$past(addr)] == '0);
endmodule

// File: rtl/tagstore_match.sv
module tagstore_match #(
    parameter int TAG_W = 12
) (
    input  logic             selected,
    input  logic             generic_mode,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic             stored_vld,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             hit
);
    logic equal;

    always_comb begin
        equal = (stored_tag == probe_tag);
        hit   = selected && equal && (generic_mode || stored_vld);
    end
endmodule

// File: rtl/tagstore_rdy.sv
module tagstore_rdy (
    input  logic hit,
    input  logic stored_wt,
    input  logic generic_mode,
    input  logic bus_write,
    input  logic force_hi,
    input  logic ext_rdy_n,
    input  logic rdy_oe,
    output logic brdy_n
);
    logic write_ok;
    logic internal_rdy;

    always_comb begin
        write_ok     = generic_mode || !stored_wt;
        internal_rdy = hit && (!bus_write || write_ok);
        brdy_n       = !(rdy_oe && !force_hi && (!ext_rdy_n || internal_rdy));
    end
endmodule

// File: rtl/tagstore_cmp.sv
module tagstore_cmp
    import tagstore_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              inval_n,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic [2:0]        stat_in,
    input  logic              tag_wr,
    input  logic              stat_wr,
    input  logic              tag_oe,
    input  logic              stat_oe,
    input  logic              generic_mode,
    input  logic              bus_write,
    input  logic              rdy_force_hi,
    input  logic              rdy_ext_n,
    input  logic              rdy_oe,
    output logic [TAG_W-1:0]  tag_out,
    output logic [2:0]        stat_out,
    output logic              hit,
    output logic              brdy_n
);
    logic             selected;
    logic [TAG_W-1:0] tag_rd;
    stat_t            stat_rd;

    assign selected = !sel0_n && sel1;

    tagstore_array #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_array (
        .clk        (clk),
        .inval_n    (inval_n),
        .wr_tag     (selected && tag_wr),
        .wr_stat    (selected && stat_wr),
        .addr       (addr),
        .tag_wdata  (tag_in),
        .stat_wdata (stat_t'(stat_in)),
        .tag_rd     (tag_rd),
        .stat_rd    (stat_rd)
    );

    tagstore_match #(.TAG_W(TAG_W)) u_match (
        .selected     (selected),
        .generic_mode (generic_mode),
        .stored_tag   (tag_rd),
        .stored_vld   (stat_rd.vld),
        .probe_tag    (tag_in),
        .hit          (hit)
    );

    tagstore_rdy u_rdy (
        .hit          (hit),
        .stored_wt    (stat_rd.wt),
        .generic_mode (generic_mode),
        .bus_write    (bus_write),
        .force_hi     (rdy_force_hi),
        .ext_rdy_n    (rdy_ext_n),
        .rdy_oe       (rdy_oe),
        .brdy_n       (brdy_n)
    );

    always_comb begin
        tag_out  = (selected && tag_oe)  ? tag_rd : '0;
        stat_out = (selected && stat_oe) ? 3'(stat_rd) : '0;
    end

    logic past_ok = 1'b0;
    always_ff @(posedge clk) past_ok <= 1'b1;

    assert_hit_tags_equal_R2: assert property (@(posedge clk) disable iff (!past_ok)
        hit |-> tag_rd == tag_in);

    assert_hit_needs_valid_R6: assert property (@(posedge clk) disable iff (!past_ok)
        (hit && !generic_mode) |-> stat_rd.vld);

    assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (!past_ok)
        !selected |-> (!hit && tag_out == '0 && stat_out == '0));

    assert_rdy_forced_off_R11: assert property (@(posedge clk) disable iff (!past_ok)
        (rdy_force_hi || !rdy_oe) |-> brdy_n);
endmodule

// File: tb/tagstore_cmp_tb.sv
module tagstore_cmp_tb;
    localparam int ADDR_W = 8;
    localparam int TAG_W  = 12;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int CLK_P  = 4;

    logic              clk = 1'b0;
    logic              inval_n, sel0_n, sel1;
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag_in;
    logic [2:0]        stat_in;
    logic              tag_wr, stat_wr, tag_oe, stat_oe, generic_mode;
    logic              bus_write, rdy_force_hi, rdy_ext_n, rdy_oe;
    logic [TAG_W-1:0]  tag_out;
    logic [2:0]        stat_out;
    logic              hit, brdy_n;

    always #(CLK_P / 2) clk = ~clk;

    tagstore_cmp #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .inval_n(inval_n), .sel0_n(sel0_n), .sel1(sel1), .addr(addr),
        .tag_in(tag_in), .stat_in(stat_in), .tag_wr(tag_wr), .stat_wr(stat_wr),
        .tag_oe(tag_oe), .stat_oe(stat_oe), .generic_mode(generic_mode),
        .bus_write(bus_write), .rdy_force_hi(rdy_force_hi), .rdy_ext_n(rdy_ext_n),
        .rdy_oe(rdy_oe), .tag_out(tag_out), .stat_out(stat_out), .hit(hit), .brdy_n(brdy_n)
    );

    typedef struct {
        string            req;
        logic [TAG_W-1:0] tag;
        logic [2:0]       st;
        logic             hit;
        logic             brdy_n;
    } exp_t;

    exp_t             sb_q[$];
    event             smp_ev;
    int               checks = 0;
    int               errors = 0;
    bit               done   = 1'b0;
    logic [TAG_W-1:0] mdl_tag  [DEPTH];
    logic [2:0]       mdl_stat [DEPTH];

    // Expected outputs from the requirements and the bench's own memory model.
    task automatic push_expect(string req);
        exp_t e;
        logic sel, h, irdy;
        sel   = !sel0_n && sel1;
        h     = sel && (mdl_tag[addr] == tag_in) && (generic_mode || mdl_stat[addr][0]);
        irdy  = h && (!bus_write || generic_mode || !mdl_stat[addr][2]);
        e.req = req;
        e.tag = (sel && tag_oe) ? mdl_tag[addr] : '0;
        e.st  = (sel && stat_oe) ? mdl_stat[addr] : '0;
        e.hit = h;
        e.brdy_n = !(rdy_oe && !rdy_force_hi && (!rdy_ext_n || irdy));
        sb_q.push_back(e);
        -> smp_ev;
    endtask

    // Monitor: pops each expected item and compares it with the outputs.
    initial begin
        forever begin
            exp_t e;
            @(smp_ev);
            e = sb_q.pop_front();
            checks++;
            if (tag_out !== e.tag || stat_out !== e.st || hit !== e.hit || brdy_n !== e.brdy_n) begin
                errors++;
                $display("FAIL %s: got tag=%h st=%b hit=%b brdy_n=%b, exp tag=%h st=%b hit=%b brdy_n=%b",
                         e.req, tag_out, stat_out, hit, brdy_n, e.tag, e.st, e.hit, e.brdy_n);
            end
        end
    end

    task automatic idle();
        sel0_n = 1'b0; sel1 = 1'b1; tag_wr = 1'b0; stat_wr = 1'b0;
        tag_oe = 1'b0; stat_oe = 1'b0; generic_mode = 1'b0; bus_write = 1'b0;
        rdy_force_hi = 1'b0; rdy_ext_n = 1'b1; rdy_oe = 1'b0; stat_in = '0;
    endtask

    task automatic wr(int a, int t, int s, bit dt, bit ds, bit s0n = 1'b0, bit s1 = 1'b1);
        @(negedge clk);
        idle();
        sel0_n = s0n; sel1 = s1; addr = ADDR_W'(a); tag_in = TAG_W'(t);
        stat_in = 3'(s); tag_wr = dt; stat_wr = ds;
        @(posedge clk);
        #1;
        if (!s0n && s1) begin
            if (dt) mdl_tag[a] = TAG_W'(t);
            if (ds) mdl_stat[a] = 3'(s);
        end
        tag_wr = 1'b0; stat_wr = 1'b0;
    endtask

    task automatic probe(string req, int a, int t, bit gm, bit bw, bit ext_n, bit frc,
                         bit toe, bit soe, bit roe, bit s0n = 1'b0, bit s1 = 1'b1);
        @(negedge clk);
        idle();
        addr = ADDR_W'(a); tag_in = TAG_W'(t); generic_mode = gm; bus_write = bw;
        rdy_ext_n = ext_n; rdy_force_hi = frc; tag_oe = toe; stat_oe = soe; rdy_oe = roe;
        sel0_n = s0n; sel1 = s1;
        #1;
        push_expect(req);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got no completion, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        addr = '0; tag_in = '0; inval_n = 1'b0;
        foreach (mdl_stat[i]) mdl_stat[i] = '0;
        foreach (mdl_tag[i])  mdl_tag[i]  = '0;
        repeat (2) @(posedge clk);
        @(negedge clk); inval_n = 1'b1;

        wr(5,  'hABC, 0,      1'b1, 1'b0);
        wr(9,  'h123, 3'b101, 1'b1, 1'b1);
        wr(20, 'h0F0, 3'b001, 1'b1, 1'b1);

        probe("R5 reset status", 5, 'hABC, 0, 0, 1, 0, 1, 1, 1);
        probe("R6 invalid no hit", 5, 'hABC, 0, 0, 1, 0, 1, 1, 1);
        probe("R7 generic hit", 5, 'hABC, 1, 0, 1, 0, 1, 1, 1);
        probe("R1 read", 9, 'h000, 0, 0, 1, 0, 1, 1, 0);
        probe("R6 valid hit", 20, 'h0F0, 0, 0, 1, 0, 1, 1, 1);
        probe("R2 mismatch", 20, 'h0F1, 0, 0, 1, 0, 1, 1, 1);
        probe("R10 write hit wt", 9, 'h123, 0, 1, 1, 0, 1, 1, 1);
        probe("R10 write hit no wt", 20, 'h0F0, 0, 1, 1, 0, 1, 1, 1);
        probe("R7 generic write wt", 9, 'h123, 1, 1, 1, 0, 1, 1, 1);
        probe("R10 ext ready", 20, 'h000, 0, 0, 0, 0, 1, 1, 1);
        probe("R11 force", 20, 'h0F0, 0, 0, 0, 1, 1, 1, 1);
        probe("R11 oe off", 20, 'h0F0, 0, 0, 0, 0, 1, 1, 0);
        probe("R9 oe off hit", 20, 'h0F0, 0, 0, 1, 0, 0, 0, 1);
        probe("R8 sel0 off", 20, 'h0F0, 0, 0, 1, 0, 1, 1, 1, 1'b1, 1'b1);
        probe("R8 sel1 off", 20, 'h0F0, 0, 0, 1, 0, 1, 1, 1, 1'b0, 1'b0);

        wr(5, 0, 3'b011, 1'b0, 1'b1);
        probe("R4 stat write keeps tag", 5, 'hABC, 0, 0, 1, 0, 1, 1, 0);
        wr(9, 'h456, 0, 1'b1, 1'b0);
        probe("R4 tag write keeps stat", 9, 'h456, 0, 0, 1, 0, 1, 1, 0);
        wr(20, 'h777, 3'b110, 1'b1, 1'b1, 1'b1, 1'b1);
        probe("R8 write dropped", 20, 'h0F0, 0, 0, 1, 0, 1, 1, 0);
        probe("R7 generic stat readback", 9, 'h000, 1, 0, 1, 0, 0, 1, 0);

        // R3: old data visible before the edge while the write is pending.
        @(negedge clk);
        idle();
        addr = 8'd5; tag_in = 12'h5A5; tag_wr = 1'b1; tag_oe = 1'b1; stat_oe = 1'b1;
        #1;
        push_expect("R3 before edge");
        @(posedge clk);
        #1;
        tag_wr = 1'b0; mdl_tag[5] = 12'h5A5;
        push_expect("R3 after edge");

        // R12: invalidate and status write at the same edge, tag write too.
        @(negedge clk);
        idle();
        addr = 8'd20; tag_in = 12'h3C3; stat_in = 3'b111;
        tag_wr = 1'b1; stat_wr = 1'b1; inval_n = 1'b0;
        @(posedge clk);
        #1;
        tag_wr = 1'b0; stat_wr = 1'b0; inval_n = 1'b1;
        mdl_tag[20] = 12'h3C3;
        foreach (mdl_stat[i]) mdl_stat[i] = '0;
        probe("R12 inval wins", 20, 'h3C3, 0, 0, 1, 0, 1, 1, 1);
        probe("R5 other entry cleared", 5, 'h5A5, 0, 0, 1, 0, 1, 1, 1);
        probe("R5 tag kept", 9, 'h456, 0, 0, 1, 0, 1, 1, 1);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule